// File: doc/BRIEF.md
# Exception Entry State-Save Unit

This block performs the entry side of two synchronous processor exceptions: the system call trap and the single-step or branch trace trap. Each cycle the pipeline may present one completion event. The event carries flags saying whether the instruction was a branch, a return-from-interrupt, a system call, or an instruction that raised some other exception of its own. It also carries the address of the next instruction. The block decides whether an exception is taken. When one is, it updates both save/restore registers and the machine state register on one clock edge, and it emits a one-cycle redirect pulse with the vector fetch address.

The completion input has no back-pressure. The block accepts an event in every cycle where `cmp_valid` is high and has no ready signal. `vec_valid` is a single-cycle pulse and is not held. The pipeline also writes the machine state register through a plain write port. An exception entry in the same cycle overrides that write.

Bit numbering is big-endian: bit 0 is the most significant bit, so bit p sits at vector index 31-p. The machine state fields used are:

| Field | Bit |
|-------|-----|
| interrupt-little-endian | 15 |
| machine-check enable | 19 |
| single-step enable | 21 |
| branch-trace enable | 22 |
| interrupt prefix | 25 |
| decompression enable | 29 |
| little-endian | 31 |

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, `msr_q`, `srr0_q`, `srr1_q` and `vec_addr` are zero and `vec_valid` is low.
- R2: With no exception taken, a `msr_wr_en` cycle loads `msr_wr_data` into `msr_q` at the next edge.
- R3: An accepted event with `cmp_sc` high takes a system call: `vec_addr` is base + 0x00C00 and `vec_valid` is high for exactly one cycle.
- R4: With single-step enable (bit 21) set, an accepted event that is not a return-from-interrupt, not a system call and without `cmp_exc` takes a trace to base + 0x00D00.
- R5: With branch-trace enable (bit 22) set, an accepted branch event without `cmp_exc` or `cmp_sc` takes a trace. A non-branch event does not take one unless single-step enable is also set.
- R6: No trace is taken after an event with `cmp_exc` high. No exception of any kind is taken when `cmp_valid` is low. In both cases `msr_q`, `srr0_q` and `srr1_q` keep their values.
- R7: When a system call and a trace condition coincide, only the system call is taken. An exception entry overrides a same-cycle `msr_wr_en`.
- R8: On entry, `srr0_q` is loaded with `cmp_next_pc`.
- R9: On entry, `srr1_q` bits 16..31 (indices 15:0) are copied from the old machine state bits 16..31, and bits 0..15 (indices 31:16) are zero.
- R10: On entry, the interrupt prefix (bit 25) and machine-check enable (bit 19) bits are kept. Little-endian (bit 31) takes the old interrupt-little-endian (bit 15). Decompression enable (bit 29) becomes `cfg_comp_en & cfg_exc_comp_en`. All other bits are cleared.
- R11: The vector base is 0x00000000 when the old interrupt-prefix bit is clear and 0xFFF00000 when it is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Completion event present |
| cmp_branch | input | 1 | Completed instruction is a branch |
| cmp_rfi | input | 1 | Completed instruction is a return-from-interrupt |
| cmp_exc | input | 1 | Instruction raised an exception of its own |
| cmp_sc | input | 1 | Instruction is a system call |
| cmp_next_pc | input | 32 | Address of the following instruction |
| msr_wr_en | input | 1 | Machine state write strobe |
| msr_wr_data | input | 32 | Machine state write value |
| cfg_comp_en | input | 1 | Compression enable configuration |
| cfg_exc_comp_en | input | 1 | Exception compression enable configuration |
| msr_q | output | 32 | Machine state register |
| srr0_q | output | 32 | Save/restore register 0 |
| srr1_q | output | 32 | Save/restore register 1 |
| vec_valid | output | 1 | One-cycle redirect pulse |
| vec_addr | output | 32 | Vector fetch address |

## Verification
Two functions can fall in the same cycle here. A system call can meet a trace condition on the same instruction, and an exception entry can meet a machine state write. The first case is provoked by a system call event with single-step enable set. It is judged by a vector ending in 0xC00, not 0xD00. The second case is provoked by raising `msr_wr_en` with a new value in the same cycle as a system call event. It is judged by a machine state built from the old value according to R10, with the written value discarded.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned HALF = XLEN / 2;
  // big-endian bit positions
  localparam int unsigned POS_ILE  = 15;
  localparam int unsigned POS_ME   = 19;
  localparam int unsigned POS_SE   = 21;
  localparam int unsigned POS_BE   = 22;
  localparam int unsigned POS_IP   = 25;
  localparam int unsigned POS_DCMP = 29;
  localparam int unsigned POS_LE   = 31;
  // vector indices
  localparam int unsigned IX_ILE  = XLEN - 1 - POS_ILE;
  localparam int unsigned IX_ME   = XLEN - 1 - POS_ME;
  localparam int unsigned IX_SE   = XLEN - 1 - POS_SE;
  localparam int unsigned IX_BE   = XLEN - 1 - POS_BE;
  localparam int unsigned IX_IP   = XLEN - 1 - POS_IP;
  localparam int unsigned IX_DCMP = XLEN - 1 - POS_DCMP;
  localparam int unsigned IX_LE   = XLEN - 1 - POS_LE;

  localparam logic [XLEN-1:0] BASE_LOW  = 32'h0000_0000;
  localparam logic [XLEN-1:0] BASE_HIGH = 32'hFFF0_0000;
  localparam logic [XLEN-1:0] OFS_SC    = 32'h0000_0C00;
  localparam logic [XLEN-1:0] OFS_TRACE = 32'h0000_0D00;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_SC    = 2'd1,
    EXC_TRACE = 2'd2
  } exc_kind_e;
endpackage

// File: rtl/exc_select.sv
module exc_select
  import exc_entry_pkg::*;
(
  input  logic      ev_valid,
  input  logic      ev_branch,
  input  logic      ev_rfi,
  input  logic      ev_exc,
  input  logic      ev_sc,
  input  logic      step_en,
  input  logic      br_trace_en,
  output exc_kind_e kind
);
  logic trace_hit;

  always_comb begin
    trace_hit = (step_en && !ev_rfi) || (br_trace_en && ev_branch);
    kind = EXC_NONE;
    if (ev_valid) begin
      if (ev_sc)                        kind = EXC_SC;
      else if (!ev_exc && trace_hit)    kind = EXC_TRACE;
    end
  end
endmodule

// File: rtl/exc_state_build.sv
module exc_state_build
  import exc_entry_pkg::*;
(
  input  logic [XLEN-1:0] msr_old,
  input  logic            comp_en,
  input  logic            exc_comp_en,
  output logic [XLEN-1:0] msr_new,
  output logic [XLEN-1:0] srr1_new
);
  always_comb begin
    msr_new          = '0;
    msr_new[IX_IP]   = msr_old[IX_IP];
    msr_new[IX_ME]   = msr_old[IX_ME];
    msr_new[IX_LE]   = msr_old[IX_ILE];
    msr_new[IX_DCMP] = comp_en & exc_comp_en;
    srr1_new         = {{HALF{1'b0}}, msr_old[HALF-1:0]};
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_entry_pkg::*;
(
  input  logic            prefix,
  input  exc_kind_e       kind,
  output logic [XLEN-1:0] addr
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] ofs;

  always_comb begin
    base = prefix ? BASE_HIGH : BASE_LOW;
    ofs  = (kind == EXC_TRACE) ? OFS_TRACE : OFS_SC;
    addr = base | ofs;
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmp_valid,
  input  logic            cmp_branch,
  input  logic            cmp_rfi,
  input  logic            cmp_exc,
  input  logic            cmp_sc,
  input  logic [XLEN-1:0] cmp_next_pc,
  input  logic            msr_wr_en,
  input  logic [XLEN-1:0] msr_wr_data,
  input  logic            cfg_comp_en,
  input  logic            cfg_exc_comp_en,
  output logic [XLEN-1:0] msr_q,
  output logic [XLEN-1:0] srr0_q,
  output logic [XLEN-1:0] srr1_q,
  output logic            vec_valid,
  output logic [XLEN-1:0] vec_addr
);
  exc_kind_e       kind;
  logic [XLEN-1:0] msr_entry;
  logic [XLEN-1:0] srr1_entry;
  logic [XLEN-1:0] vec_next;
  logic            take;

  exc_select u_sel (
    .ev_valid    (cmp_valid),
    .ev_branch   (cmp_branch),
    .ev_rfi      (cmp_rfi),
    .ev_exc      (cmp_exc),
    .ev_sc       (cmp_sc),
    .step_en     (msr_q[IX_SE]),
    .br_trace_en (msr_q[IX_BE]),
    .kind        (kind)
  );

  exc_state_build u_build (
    .msr_old     (msr_q),
    .comp_en     (cfg_comp_en),
    .exc_comp_en (cfg_exc_comp_en),
    .msr_new     (msr_entry),
    .srr1_new    (srr1_entry)
  );

  exc_vector u_vec (
    .prefix (msr_q[IX_IP]),
    .kind   (kind),
    .addr   (vec_next)
  );

  assign take = (kind != EXC_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msr_q     <= '0;
      srr0_q    <= '0;
      srr1_q    <= '0;
      vec_valid <= 1'b0;
      vec_addr  <= '0;
    end else begin
      vec_valid <= take;
      if (take) begin
        msr_q    <= msr_entry;
        srr0_q   <= cmp_next_pc;
        srr1_q   <= srr1_entry;
        vec_addr <= vec_next;
      end else if (msr_wr_en) begin
        msr_q <= msr_wr_data;
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            cmp_valid,
  input logic            cmp_exc,
  input logic            cmp_sc,
  input logic [XLEN-1:0] cmp_next_pc,
  input logic            cfg_comp_en,
  input logic            cfg_exc_comp_en,
  input logic [XLEN-1:0] msr_q,
  input logic [XLEN-1:0] srr0_q,
  input logic [XLEN-1:0] srr1_q,
  input logic            vec_valid,
  input logic [XLEN-1:0] vec_addr
);
  p_no_entry_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> !vec_valid);

  p_no_trace_after_exc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_exc && !cmp_sc) |=> !vec_valid);

  p_sc_vector_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_sc) |=> (vec_valid && vec_addr[11:0] == 12'hC00));

  p_srr0_next_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_sc) |=> (srr0_q == $past(cmp_next_pc)));

  p_srr1_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (srr1_q[XLEN-1:HALF] == '0));

  p_le_from_ile_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_sc) |=> (msr_q[IX_LE] == $past(msr_q[IX_ILE])
                               && msr_q[IX_ME] == $past(msr_q[IX_ME])));

  p_dcmp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_sc) |=> (msr_q[IX_DCMP] == $past(cfg_comp_en & cfg_exc_comp_en)));

  p_base_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_sc) |=>
      (vec_addr[XLEN-1:20] == ($past(msr_q[IX_IP]) ? 12'hFFF : 12'h000)));
endmodule

bind exc_entry_unit exc_entry_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cmp_valid       (cmp_valid),
  .cmp_exc         (cmp_exc),
  .cmp_sc          (cmp_sc),
  .cmp_next_pc     (cmp_next_pc),
  .cfg_comp_en     (cfg_comp_en),
  .cfg_exc_comp_en (cfg_exc_comp_en),
  .msr_q           (msr_q),
  .srr0_q          (srr0_q),
  .srr1_q          (srr1_q),
  .vec_valid       (vec_valid),
  .vec_addr        (vec_addr)
);

// File: tb/sim_exc_entry_unit.sv
module sim_exc_entry_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // entry: {msr[31:0], sc, exc, br, rfi, ca, cb}
  localparam logic [37:0] TBL [NVEC] = '{
    {32'h0000_0000, 6'b100000},
    {32'h0001_1040, 6'b100011},
    {32'h0000_0400, 6'b000011},
    {32'h0000_0400, 6'b000100},
    {32'h0000_0200, 6'b001001},
    {32'h0000_0200, 6'b000011},
    {32'h0000_0400, 6'b010000},
    {32'h0000_0400, 6'b100000},
    {32'hFFFF_FFFF, 6'b001010},
    {32'h0000_0600, 6'b000110}
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmp_valid = 0, cmp_branch = 0, cmp_rfi = 0, cmp_exc = 0, cmp_sc = 0;
  logic [31:0] cmp_next_pc = 0;
  logic        msr_wr_en = 0;
  logic [31:0] msr_wr_data = 0;
  logic        cfg_comp_en = 0, cfg_exc_comp_en = 0;
  logic [31:0] msr_q, srr0_q, srr1_q, vec_addr;
  logic        vec_valid;

  int checks = 0;
  int fails = 0;
  logic [31:0] exp_srr0, exp_srr1;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_unit u0 (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_branch(cmp_branch),
    .cmp_rfi(cmp_rfi), .cmp_exc(cmp_exc), .cmp_sc(cmp_sc), .cmp_next_pc(cmp_next_pc),
    .msr_wr_en(msr_wr_en), .msr_wr_data(msr_wr_data), .cfg_comp_en(cfg_comp_en),
    .cfg_exc_comp_en(cfg_exc_comp_en), .msr_q(msr_q), .srr0_q(srr0_q),
    .srr1_q(srr1_q), .vec_valid(vec_valid), .vec_addr(vec_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // model built from the requirements (big-endian bit p -> index 31-p)
  function automatic logic [31:0] m_msr(input logic [31:0] m, input logic ca, input logic cb);
    logic [31:0] r = '0;
    r[31-25] = m[31-25];
    r[31-19] = m[31-19];
    r[31-31] = m[31-15];
    r[31-29] = ca & cb;
    return r;
  endfunction

  function automatic logic [1:0] m_kind(input logic [31:0] m, input logic sc,
                                        input logic exc, input logic br, input logic rfi);
    if (sc) return 2'd1;
    if (!exc && ((m[31-21] && !rfi) || (m[31-22] && br))) return 2'd2;
    return 2'd0;
  endfunction

  task automatic write_msr(input logic [31:0] v);
    msr_wr_en = 1; msr_wr_data = v;
    @(posedge clk); #1;
    msr_wr_en = 0;
  endtask

  task automatic event_run(input logic sc, input logic exc, input logic br, input logic rfi,
                           input logic ca, input logic cb, input logic [31:0] pc);
    cmp_valid = 1; cmp_sc = sc; cmp_exc = exc; cmp_branch = br; cmp_rfi = rfi;
    cfg_comp_en = ca; cfg_exc_comp_en = cb; cmp_next_pc = pc;
    @(posedge clk); #1;
    cmp_valid = 0; cmp_sc = 0; cmp_exc = 0; cmp_branch = 0; cmp_rfi = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 msr", msr_q, 0);
    check("R1 srr0", srr0_q, 0);
    check("R1 srr1", srr1_q, 0);
    check("R1 vec_valid", {31'b0, vec_valid}, 0);
    check("R1 vec_addr", vec_addr, 0);
    rst_n = 1;
    exp_srr0 = 0; exp_srr1 = 0;

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] m;
      logic sc, exc, br, rfi, ca, cb;
      logic [1:0] k;
      logic [31:0] pc;
      {m, sc, exc, br, rfi, ca, cb} = TBL[i];
      pc = 32'h0000_1000 + 32'(i) * 4;
      write_msr(m);
      check("R2 msr write", msr_q, m);
      k = m_kind(m, sc, exc, br, rfi);
      event_run(sc, exc, br, rfi, ca, cb, pc);
      if (k != 2'd0) begin
        exp_srr0 = pc;
        exp_srr1 = {16'h0, m[15:0]};
        check("R3/R4/R5/R7 taken", {31'b0, vec_valid}, 1);
        check("R11 vector", vec_addr,
              (m[31-25] ? 32'hFFF0_0000 : 32'h0) | (k == 2'd1 ? 32'h0C00 : 32'h0D00));
        check("R10 msr", msr_q, m_msr(m, ca, cb));
        check("R8 srr0", srr0_q, exp_srr0);
        check("R9 srr1", srr1_q, exp_srr1);
        @(posedge clk); #1;
        check("R3 single pulse", {31'b0, vec_valid}, 0);
      end else begin
        check("R6 not taken", {31'b0, vec_valid}, 0);
        check("R6 msr kept", msr_q, m);
        check("R6 srr0 kept", srr0_q, exp_srr0);
        check("R6 srr1 kept", srr1_q, exp_srr1);
      end
    end

    // R6: no event valid, syscall flag alone does nothing
    write_msr(32'h0000_0400);
    cmp_sc = 1; cmp_next_pc = 32'hDEAD_0000;
    @(posedge clk); #1;
    cmp_sc = 0;
    check("R6 idle valid", {31'b0, vec_valid}, 0);
    check("R6 idle srr0", srr0_q, exp_srr0);

    // R7: exception beats a same-cycle machine state write
    write_msr(32'h0001_1000);
    msr_wr_en = 1; msr_wr_data = 32'h0000_FFFF;
    event_run(1, 0, 0, 0, 1, 1, 32'h0000_2000);
    msr_wr_en = 0;
    check("R7 write overridden", msr_q, 32'h0000_1005);
    check("R7 vector", vec_addr, 32'h0000_0C00);
    check("R9 srr1", srr1_q, 32'h0000_1000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule